// File: doc/BRIEF.md
# Shared Channel Semaphore with Read-Side Acquire

This block arbitrates one auxiliary channel between two agents: software, which reaches it through a single memory-mapped word on a register bus, and an autonomous hardware engine that may start channel transactions on its own. Software does not ask for the lock with a command. Reading the semaphore word is the request. The status bit in the returned word tells the reader whether that read won the lock.

Software gives the lock back by writing the status bit as one with the enable bit also set. The hardware engine uses a request/grant pair. It holds the lock for as long as it keeps its request high. The lock applies only while the enable bit is set. With the enable clear, nobody takes the lock, and the hardware engine is granted the channel without arbitration. A 2-bit owner output tells the channel engine which agent is driving it.

Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and reads as zero in any cycle that did not follow a read. Owner and enable changes take effect at the clock edge that samples the strobe or request.

Top module: `chan_sem`

## Requirements
- R1: After reset the enable is clear, `lock_owner` is 0 (free, encoding 0 free, 1 software, 2 hardware), `hw_gnt` is 1 and `bus_rdata` is 0.
- R2: A write with bit 31 = 1 and bit 30 = 0 sets the enable bit and leaves the owner unchanged. Bit 31 of later read data shows the enable.
- R3: A read with no write in the same cycle, while enabled, free and with `hw_req` low, makes software the owner from the next cycle. The returned word has bit 30 = 0 and bit 31 = 1.
- R4: A read that loses (lock held by hardware, or enable clear) returns bit 30 = 1 and leaves the owner unchanged.
- R5: While enabled and free, a high `hw_req` makes hardware the owner from the next cycle, with `hw_gnt` = 1. While enabled, `hw_gnt` is 0 unless hardware owns the lock.
- R6: When hardware owns the lock and `hw_req` is low at a clock edge, the lock is free from the next cycle.
- R7: A read and a high `hw_req` in the same cycle with the lock free and enabled give the lock to hardware. The read returns bit 30 = 1.
- R8: A write of bits 31 and 30 both 1 while software owns the lock frees it and keeps the enable set.
- R9: A release write (bits 31 and 30 both 1) while hardware owns the lock or the lock is free has no effect on the owner.
- R10: A write with bit 31 = 0 clears the enable and frees the lock from either owner. While the enable is clear, `hw_req` never takes the lock and `hw_gnt` is 1.
- R11: Bits 29:0 of read data are always 0, whatever was written. A read by the current software owner returns bit 30 = 0 and keeps the lock.
- R12: A read in the same cycle as a write does not acquire the lock. Its status bit reflects the state after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data (bit 31 enable, bit 30 status/release) |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| hw_req | input | 1 | Hardware engine lock request |
| hw_gnt | output | 1 | Channel granted to the hardware engine |
| lock_owner | output | 2 | Current owner: 0 free, 1 software, 2 hardware |

## Verification
The hardest situations to reach are collisions in one cycle: a read that lands in the same cycle as a hardware request on a free lock, a release write that meets a hardware request that is already waiting, and a disable write while hardware holds the lock. The bench drives strobes and requests together on the falling edge, so each collision reaches the design in one chosen clock edge. A behavioural model predicts the owner, grant and read word, and the bench compares them every cycle.

// File: rtl/chan_sem_pkg.sv
package chan_sem_pkg;

  typedef enum logic [1:0] {
    OWN_FREE = 2'b00,
    OWN_SW   = 2'b01,
    OWN_HW   = 2'b10
  } owner_e;

  // status bit returned to a reader: 0 means software holds the lock
  function automatic logic lock_status(input owner_e own_after);
    return (own_after != OWN_SW);
  endfunction

  // a release write must carry both control bits set
  function automatic logic is_release(input logic en_b, input logic st_b);
    return en_b & st_b;
  endfunction

endpackage

// File: rtl/chan_sem_decode.sv
module chan_sem_decode (
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic wbit_en,
  input  logic wbit_st,
  output logic ev_rd_req,
  output logic ev_set_en,
  output logic ev_clr_en,
  output logic ev_release
);
  import chan_sem_pkg::*;

  always_comb begin
    ev_rd_req  = bus_rd & ~bus_wr;
    ev_set_en  = bus_wr & wbit_en;
    ev_clr_en  = bus_wr & ~wbit_en;
    ev_release = bus_wr & is_release(wbit_en, wbit_st);
  end
endmodule

// File: rtl/chan_sem_arb.sv
module chan_sem_arb
  import chan_sem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_rd_req,
  input  logic   ev_set_en,
  input  logic   ev_clr_en,
  input  logic   ev_release,
  input  logic   hw_req,
  output logic   en_q,
  output owner_e own_q,
  output logic   en_n,
  output owner_e own_n,
  output logic   ev_acq_sw,
  output logic   ev_acq_hw,
  output logic   ev_rel_sw,
  output logic   ev_rel_hw
);

  always_comb begin
    en_n      = en_q;
    own_n     = own_q;
    ev_acq_sw = 1'b0;
    ev_acq_hw = 1'b0;
    ev_rel_sw = 1'b0;
    ev_rel_hw = 1'b0;
    if (ev_clr_en) begin
      en_n      = 1'b0;
      own_n     = OWN_FREE;
      ev_rel_sw = (own_q == OWN_SW);
      ev_rel_hw = (own_q == OWN_HW);
    end else begin
      if (ev_set_en) en_n = 1'b1;
      if (ev_release && own_q == OWN_SW) begin
        own_n     = OWN_FREE;
        ev_rel_sw = 1'b1;
      end else if (own_q == OWN_HW && !hw_req) begin
        own_n     = OWN_FREE;
        ev_rel_hw = 1'b1;
      end else if (en_q && own_q == OWN_FREE) begin
        if (hw_req) begin
          own_n     = OWN_HW;
          ev_acq_hw = 1'b1;
        end else if (ev_rd_req) begin
          own_n     = OWN_SW;
          ev_acq_sw = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      own_q <= OWN_FREE;
    end else begin
      en_q  <= en_n;
      own_q <= own_n;
    end
  end
endmodule

// File: rtl/chan_sem_rdata.sv
module chan_sem_rdata
  import chan_sem_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 31,
  parameter int LOCK_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              en_n,
  input  owner_e            own_n,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [DATA_W-1:0] word_n;

  always_comb begin
    word_n           = '0;
    word_n[EN_BIT]   = en_n;
    word_n[LOCK_BIT] = lock_status(own_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? word_n : '0;
  end
endmodule

// File: rtl/chan_sem.sv
module chan_sem
  import chan_sem_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 31,
  parameter int LOCK_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_req,
  output logic              hw_gnt,
  output logic [1:0]        lock_owner
);

  logic   ev_rd_req, ev_set_en, ev_clr_en, ev_release;
  logic   ev_acq_sw, ev_acq_hw, ev_rel_sw, ev_rel_hw;
  logic   en_q, en_n;
  owner_e own_q, own_n;
  logic   unused_wbits;

  assign unused_wbits = ^bus_wdata;

  chan_sem_decode u_dec (
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .wbit_en    (bus_wdata[EN_BIT]),
    .wbit_st    (bus_wdata[LOCK_BIT]),
    .ev_rd_req  (ev_rd_req),
    .ev_set_en  (ev_set_en),
    .ev_clr_en  (ev_clr_en),
    .ev_release (ev_release)
  );

  chan_sem_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_rd_req  (ev_rd_req),
    .ev_set_en  (ev_set_en),
    .ev_clr_en  (ev_clr_en),
    .ev_release (ev_release),
    .hw_req     (hw_req),
    .en_q       (en_q),
    .own_q      (own_q),
    .en_n       (en_n),
    .own_n      (own_n),
    .ev_acq_sw  (ev_acq_sw),
    .ev_acq_hw  (ev_acq_hw),
    .ev_rel_sw  (ev_rel_sw),
    .ev_rel_hw  (ev_rel_hw)
  );

  chan_sem_rdata #(
    .DATA_W   (DATA_W),
    .EN_BIT   (EN_BIT),
    .LOCK_BIT (LOCK_BIT)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .en_n      (en_n),
    .own_n     (own_n),
    .bus_rdata (bus_rdata)
  );

  assign lock_owner = own_q;
  assign hw_gnt     = (own_q == OWN_HW) | ~en_q;

endmodule

// File: rtl/chan_sem_chk.sv
module chan_sem_chk #(
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 31,
  parameter int LOCK_BIT = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              hw_req,
  input logic              hw_gnt,
  input logic [1:0]        lock_owner,
  input logic              en_q,
  input logic              ev_acq_sw,
  input logic              ev_acq_hw,
  input logic              ev_rel_sw,
  input logic              ev_rel_hw
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << LOCK_BIT);

  a_r3_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && en_q && lock_owner == 2'd0 && !hw_req)
    |=> (lock_owner == 2'd1 && !bus_rdata[LOCK_BIT]));

  a_r4_lose_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && lock_owner == 2'd2 && hw_req)
    |=> (lock_owner == 2'd2 && bus_rdata[LOCK_BIT]));

  a_r5_gnt_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && lock_owner != 2'd2) |-> !hw_gnt);

  a_r6_hw_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_owner == 2'd2 && !hw_req) |=> (lock_owner == 2'd0));

  a_r7_tie_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && en_q && lock_owner == 2'd0 && hw_req)
    |=> (lock_owner == 2'd2 && bus_rdata[LOCK_BIT]));

  a_r10_disable_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[EN_BIT]) |=> (lock_owner == 2'd0 && hw_gnt));

  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~CTRL_MASK) == '0));

  a_r12_events_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_acq_sw, ev_acq_hw, ev_rel_sw, ev_rel_hw}));
endmodule

bind chan_sem chan_sem_chk #(
  .DATA_W   (DATA_W),
  .EN_BIT   (EN_BIT),
  .LOCK_BIT (LOCK_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .hw_req     (hw_req),
  .hw_gnt     (hw_gnt),
  .lock_owner (lock_owner),
  .en_q       (en_q),
  .ev_acq_sw  (ev_acq_sw),
  .ev_acq_hw  (ev_acq_hw),
  .ev_rel_sw  (ev_rel_sw),
  .ev_rel_hw  (ev_rel_hw)
);

// File: tb/chan_sem_bench.sv
module chan_sem_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_req = 1'b0;
  logic        hw_gnt;
  logic [1:0]  lock_owner;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state: 0 free, 1 software, 2 hardware
  int m_own = 0;
  int m_en  = 0;
  logic [31:0] m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_sem u_chan_sem (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .hw_req     (hw_req),
    .hw_gnt     (hw_gnt),
    .lock_owner (lock_owner)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    logic exp_gnt;
    exp_gnt = (m_own == 2) || (m_en == 0);
    check(req, "owner", {30'd0, lock_owner}, m_own);
    check(req, "hw_gnt", {31'd0, hw_gnt}, {31'd0, exp_gnt});
    check(req, "rdata", bus_rdata, m_rdata);
  endtask

  // one cycle: drive, update the model for the coming edge, compare after it
  task automatic step(input string req, input bit rd, input bit wr,
                      input logic [31:0] wd, input bit hw);
    int nown, nen;
    bus_rd = rd; bus_wr = wr; bus_wdata = wd; hw_req = hw;
    nown = m_own; nen = m_en;
    if (wr && !wd[31]) begin
      nen = 0; nown = 0;
    end else begin
      if (wr) nen = 1;
      if (m_own == 1 && wr && wd[30]) nown = 0;
      else if (m_own == 2) nown = hw ? 2 : 0;
      else if (m_own == 0 && m_en == 1 && hw) nown = 2;
      else if (m_own == 0 && m_en == 1 && rd && !wr) nown = 1;
    end
    m_rdata = '0;
    if (rd) begin
      m_rdata[31] = (nen == 1);
      m_rdata[30] = (nown != 1);
    end
    m_own = nown; m_en = nen;
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    step("R1", 0, 0, 32'h0, 0);
    step("R4", 1, 0, 32'h0, 0);            // read while disabled
    step("R10", 0, 0, 32'h0, 1);           // hw while disabled
    step("R2", 0, 1, 32'h8000_0000, 0);    // enable
    step("R3", 1, 0, 32'h0, 0);            // winning read
    step("R11", 1, 0, 32'h0, 1);           // owner re-read, hw waits
    step("R5", 0, 0, 32'h0, 1);
    step("R8", 0, 1, 32'hC000_0000, 1);    // release with hw waiting
    step("R5", 0, 0, 32'h0, 1);            // hw acquires
    step("R4", 1, 0, 32'h0, 1);            // losing read
    step("R9", 0, 1, 32'hC000_0000, 1);    // release from non-holder
    step("R6", 0, 0, 32'h0, 0);            // hw drops
    step("R6", 0, 0, 32'h0, 0);
    step("R9", 0, 1, 32'hC000_0000, 0);    // release while free
    step("R7", 1, 0, 32'h0, 1);            // tie goes to hw
    step("R6", 0, 0, 32'h0, 0);
    step("R12", 1, 1, 32'h8000_0000, 0);   // read with write
    step("R3", 1, 0, 32'h0, 0);
    step("R10", 0, 1, 32'h0000_0000, 0);   // disable frees sw
    step("R4", 1, 0, 32'h0, 0);
    step("R10", 0, 0, 32'h0, 1);
    step("R2", 0, 1, 32'h8000_0000, 1);
    step("R5", 0, 0, 32'h0, 1);
    step("R10", 0, 1, 32'h0000_0000, 1);   // disable frees hw
    step("R10", 0, 0, 32'h0, 1);
    step("R11", 0, 1, 32'h8000_FFFF, 0);   // junk low bits
    step("R11", 1, 0, 32'h0, 0);
    step("R12", 1, 1, 32'hC000_0000, 0);   // read with release
    step("R1", 0, 0, 32'h0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule